// File: doc/BRIEF.md
# Converter Conversion and Readout Sequencer

This block sits on the host side of a 12-bit successive-approximation converter that has a parallel, processor-style bus. A one-cycle start request makes it drive a write cycle to the converter, which starts a conversion. It then waits for the end of the conversion in one of two ways. In the first, it watches the converter's busy status line. In the second, it waits a fixed number of clock cycles that covers the worst-case conversion time of 10 µs. The default `TIMEOUT_CYC` of 1000 is that time at a 100 MHz clock.

After the wait it reads the result back over the bus. On a 16-bit bus this takes one word read. On an 8-bit bus it takes two byte reads, and the second byte carries the low nibble left-justified. The block rebuilds the 12-bit value, presents it with a one-cycle valid strobe, and keeps a busy output high for the whole sequence. In status mode a watchdog of twice the timeout returns the sequencer to idle and raises an error flag if the converter never reports completion.

Top module: `adc_seq`

## Requirements
- R1: After reset, `cs_n_o`, `wr_n_o` and `rd_n_o` are high, and `busy_o`, `result_valid_o` and `err_o` are low.
- R2: A `start_i` sampled high while `busy_o` is low starts a write cycle on the next cycle. During the write cycle `cs_n_o` and `wr_n_o` are low and `a0_o` is low for exactly `ACCESS_CYC` cycles. `busy_o` rises together with the write strobe and stays high until `result_valid_o` is pulsed.
- R3: `start_i` has no effect while `busy_o` is high, so only one write cycle is issued per accepted start. `poll_mode_i` and `wide_mode_i` are sampled only when a start is accepted.
- R4: In status mode (`poll_mode_i`=1), the end of conversion is `conv_busy_i` seen high and then low. The first read strobe falls one cycle after the cycle in which the sequencer first samples `conv_busy_i` low.
- R5: In timeout mode (`poll_mode_i`=0), `conv_busy_i` is ignored. The first read strobe falls exactly `TIMEOUT_CYC` cycles after the write strobe ends.
- R6: In status mode, if the conversion has not ended `2*TIMEOUT_CYC` cycles after the write strobe ends, the sequencer makes no read, drops `busy_o` and raises `err_o`. `err_o` stays high until the next start is accepted.
- R7: Each read holds `cs_n_o` and `rd_n_o` low for exactly `ACCESS_CYC` cycles, and `data_i` is sampled in the last of those cycles. Write and read strobes are never low together, and neither is low while `cs_n_o` is high.
- R8: In 16-bit mode (`wide_mode_i`=1) there is one read with `a0_o`=0. The result is `data_i[11:0]`, and `data_i[15:12]` is ignored.
- R9: In 8-bit mode there are two reads. The first has `a0_o`=0 and returns result bits 11:4 on `data_i[7:0]`. The second has `a0_o`=1 and returns result bits 3:0 on `data_i[7:4]`. `data_i[3:0]` and `data_i[15:8]` are ignored.
- R10: `result_valid_o` is high for exactly one cycle, in the cycle right after the last read strobe ends. `result_o` holds its value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request |
| poll_mode_i | input | 1 | 1: wait on converter status, 0: fixed wait |
| wide_mode_i | input | 1 | 1: one 16-bit read, 0: two byte reads |
| conv_busy_i | input | 1 | Converter status, high while converting |
| data_i | input | 16 | Converter data bus |
| cs_n_o | output | 1 | Converter chip select, active low |
| wr_n_o | output | 1 | Write strobe (conversion start), active low |
| rd_n_o | output | 1 | Read enable, active low |
| a0_o | output | 1 | Byte address bit: 0 high byte, 1 low byte |
| busy_o | output | 1 | Sequence in progress |
| result_o | output | 12 | Assembled conversion result |
| result_valid_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Status watchdog expired |

## Verification
All four combinations of bus width and end-of-conversion method are run. Each word carries junk in the bus bits that must be masked, and the junk differs per position, so a wrong byte order, an unshifted nibble or a missing mask gives a visibly wrong result. In status mode, one conversion is shorter than the timeout and one is longer. Read timing that follows the status edge in both cases cannot come from a hidden fixed wait. Timeout mode runs with a status line stuck high, which shows that status is ignored. A stuck status line in status mode drives the watchdog path. A start pulse and mode changes made during a conversion confirm that they are ignored and that the modes are latched.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int RES_W = 12;
  localparam int BUS_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE, ST_WAIT, ST_RD_HI, ST_GAP, ST_RD_LO
  } seq_state_t;

  // full-width read: keep the low result bits, drop the unused top of the bus
  function automatic logic [RES_W-1:0] word_result(input logic [BUS_W-1:0] w);
    return w[RES_W-1:0];
  endfunction

  // byte reads: high byte is bits 11:4, low nibble sits in bits 7:4 of second byte
  function automatic logic [RES_W-1:0] byte_result(input logic [7:0] hi,
                                                   input logic [7:0] lo);
    return {hi, lo[7:4]};
  endfunction
endpackage

// File: rtl/adc_seq_cnt.sv
module adc_seq_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // a loaded count reaches zero only by stepping down, never by wrapping
  assert_cnt_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_i) && ($past(cnt_q) == '0) |-> cnt_q == '0);
endmodule

// File: rtl/adc_seq_asm.sv
module adc_seq_asm
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_word_i,
  input  logic             cap_hi_i,
  input  logic             cap_lo_i,
  input  logic [BUS_W-1:0] data_i,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [7:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q     <= '0;
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= cap_word_i | cap_lo_i;
      if (cap_hi_i)   hi_q     <= data_i[7:0];
      if (cap_word_i) result_o <= word_result(data_i);
      if (cap_lo_i)   result_o <= byte_result(hi_q, data_i[7:0]);
    end
  end

  assert_valid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(result_o));
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1000,
  parameter int ACCESS_CYC  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             poll_mode_i,
  input  logic             wide_mode_i,
  input  logic             conv_busy_i,
  input  logic [BUS_W-1:0] data_i,
  output logic             cs_n_o,
  output logic             wr_n_o,
  output logic             rd_n_o,
  output logic             a0_o,
  output logic             busy_o,
  output logic [RES_W-1:0] result_o,
  output logic             result_valid_o,
  output logic             err_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int WDOG_CYC = 2 * TIMEOUT_CYC;
  localparam int ACC_W    = $clog2(ACCESS_CYC + 1);
  localparam int WAIT_W   = $clog2(WDOG_CYC + 1);
  localparam logic [ACC_W-1:0]  ACC_LD = ACC_W'(ACCESS_CYC - 1);
  localparam logic [WAIT_W-1:0] TMO_LD = WAIT_W'(TIMEOUT_CYC - 1);
  localparam logic [WAIT_W-1:0] WDG_LD = WAIT_W'(WDOG_CYC - 1);

  seq_state_t st_q, st_d;
  logic poll_q, wide_q, seen_hi_q, err_q;

  // named internal events
  logic go_write, acc_done, wait_zero, eoc, wdog_fire;
  logic go_rd_hi, go_rd_lo, acc_load, wait_load;
  logic cap_word, cap_hi, cap_lo;

  assign go_write  = (st_q == ST_IDLE) && start_i;
  assign eoc       = poll_q ? (seen_hi_q && !conv_busy_i) : wait_zero;
  assign wdog_fire = (st_q == ST_WAIT) && poll_q && wait_zero && !eoc;
  assign go_rd_hi  = (st_q == ST_WAIT) && eoc;
  assign go_rd_lo  = (st_q == ST_GAP);
  assign acc_load  = go_write || go_rd_hi || go_rd_lo;
  assign wait_load = (st_q == ST_WRITE) && acc_done;
  assign cap_word  = (st_q == ST_RD_HI) && acc_done && wide_q;
  assign cap_hi    = (st_q == ST_RD_HI) && acc_done && !wide_q;
  assign cap_lo    = (st_q == ST_RD_LO) && acc_done;

  adc_seq_cnt #(.W(ACC_W)) u_acc_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(acc_load), .val_i(ACC_LD), .zero_o(acc_done)
  );

  adc_seq_cnt #(.W(WAIT_W)) u_wait_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(wait_load),
    .val_i(poll_q ? WDG_LD : TMO_LD), .zero_o(wait_zero)
  );

  adc_seq_asm u_asm (
    .clk(clk), .rst_n(rst_n), .cap_word_i(cap_word), .cap_hi_i(cap_hi),
    .cap_lo_i(cap_lo), .data_i(data_i), .result_o(result_o), .valid_o(result_valid_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (go_write) st_d = ST_WRITE;
      ST_WRITE: if (acc_done) st_d = ST_WAIT;
      ST_WAIT:  if (go_rd_hi) st_d = ST_RD_HI;
                else if (wdog_fire) st_d = ST_IDLE;
      ST_RD_HI: if (acc_done) st_d = wide_q ? ST_IDLE : ST_GAP;
      ST_GAP:   st_d = ST_RD_LO;
      ST_RD_LO: if (acc_done) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      poll_q    <= 1'b0;
      wide_q    <= 1'b0;
      seen_hi_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      st_q <= st_d;
      if (go_write) begin
        poll_q    <= poll_mode_i;
        wide_q    <= wide_mode_i;
        seen_hi_q <= 1'b0;
        err_q     <= 1'b0;
      end else begin
        if ((st_q == ST_WRITE || st_q == ST_WAIT) && conv_busy_i) seen_hi_q <= 1'b1;
        if (wdog_fire) err_q <= 1'b1;
      end
    end
  end

  assign wr_n_o = (st_q != ST_WRITE);
  assign rd_n_o = !(st_q == ST_RD_HI || st_q == ST_RD_LO);
  assign cs_n_o = wr_n_o && rd_n_o;
  assign a0_o   = (st_q == ST_RD_LO);
  assign busy_o = (st_q != ST_IDLE);
  assign err_o  = err_q;

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n_o && !rd_n_o));
  assert_strobe_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n_o || !rd_n_o) |-> !cs_n_o);
  assert_start_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n_o) |-> $past(start_i && !busy_o));
  assert_err_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !busy_o && rd_n_o && $past(!rd_n_o) == 1'b0);
  assert_valid_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> $past(!rd_n_o) && !busy_o);
  assert_busy_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n_o |-> busy_o);
endmodule

// File: tb/adc_seq_test.sv
module adc_seq_test;
  timeunit 1ns; timeprecision 1ps;

  localparam int T   = 40;
  localparam int ACC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, poll_mode_i = 1'b0, wide_mode_i = 1'b0;
  logic [15:0] data_i;
  logic cs_n_o, wr_n_o, rd_n_o, a0_o, busy_o, result_valid_o, err_o;
  logic [11:0] result_o;

  // converter model controls
  logic sts = 1'b0;
  logic hang = 1'b0;
  logic m_wide = 1'b0;
  logic [11:0] m_val = '0;
  int conv_len = 10;
  int ccnt = 0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  adc_seq #(.TIMEOUT_CYC(T), .ACCESS_CYC(ACC)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .poll_mode_i(poll_mode_i),
    .wide_mode_i(wide_mode_i), .conv_busy_i(sts), .data_i(data_i),
    .cs_n_o(cs_n_o), .wr_n_o(wr_n_o), .rd_n_o(rd_n_o), .a0_o(a0_o),
    .busy_o(busy_o), .result_o(result_o), .result_valid_o(result_valid_o),
    .err_o(err_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // converter status model
  always @(posedge clk) begin
    if (!rst_n) sts <= 1'b0;
    else if (!cs_n_o && !wr_n_o) begin sts <= 1'b1; ccnt <= conv_len; end
    else if (sts && !hang && ccnt == 0) sts <= 1'b0;
    else if (sts && ccnt != 0) ccnt <= ccnt - 1;
  end

  // converter bus model, junk placed in every bit that must be ignored
  always_comb begin
    if (!cs_n_o && !rd_n_o) begin
      if (m_wide)     data_i = {4'hA, m_val};
      else if (!a0_o) data_i = {8'h5A, m_val[11:4]};
      else            data_i = {8'hC3, m_val[3:0], 4'h9};
    end else data_i = 16'hFFFF;
  end

  // edge monitor sampled away from the active edge
  logic p_wr = 1'b1, p_rd = 1'b1, p_sts = 1'b0, p_busy = 1'b0, p_err = 1'b0;
  int wr_falls, rd_falls, v_cnt;
  int t_wr_fall, t_wr_rise, t_rd_fall1, t_rd_fall, t_rd_rise, t_sts_fall;
  int t_valid, t_busy, t_err;
  logic a0_seq [2];

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_wr && !wr_n_o) begin wr_falls++; t_wr_fall = cyc; end
      if (!p_wr && wr_n_o) t_wr_rise = cyc;
      if (p_rd && !rd_n_o) begin
        if (rd_falls < 2) a0_seq[rd_falls] = a0_o;
        rd_falls++;
        if (rd_falls == 1) t_rd_fall1 = cyc;
        t_rd_fall = cyc;
      end
      if (!p_rd && rd_n_o) t_rd_rise = cyc;
      if (p_sts && !sts) t_sts_fall = cyc;
      if (!p_busy && busy_o) t_busy = cyc;
      if (!p_err && err_o) t_err = cyc;
      if (result_valid_o) begin v_cnt++; t_valid = cyc; end
    end
    p_wr = wr_n_o; p_rd = rd_n_o; p_sts = sts; p_busy = busy_o; p_err = err_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    wr_falls = 0; rd_falls = 0; v_cnt = 0;
    a0_seq[0] = 1'b1; a0_seq[1] = 1'b0;
  endtask

  task automatic pulse_start(input bit poll, input bit wide);
    @(negedge clk);
    poll_mode_i = poll; wide_mode_i = wide; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (result_valid_o || (err_o && !busy_o)) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(cs_n_o && wr_n_o && rd_n_o, "R1 strobes idle", {cs_n_o, wr_n_o, rd_n_o}, 7);
    chk(!busy_o && !result_valid_o && !err_o, "R1 flags low",
        {busy_o, result_valid_o, err_o}, 0);
  endtask

  task automatic t_wide_poll(input logic [11:0] v, input int clen);
    clear_mon(); hang = 0; m_wide = 1; m_val = v; conv_len = clen;
    pulse_start(1, 1);
    wait_end();
    chk(result_o == v, "R8 wide result", result_o, v);
    chk(rd_falls == 1 && a0_seq[0] == 1'b0, "R8 one read a0=0", rd_falls, 1);
    chk(t_rd_fall1 - t_sts_fall == 1, "R4 read after status", t_rd_fall1 - t_sts_fall, 1);
    chk(t_wr_rise - t_wr_fall == ACC, "R2 write width", t_wr_rise - t_wr_fall, ACC);
    chk(t_busy == t_wr_fall, "R2 busy with write", t_busy, t_wr_fall);
    chk(t_rd_rise - t_rd_fall == ACC, "R7 read width", t_rd_rise - t_rd_fall, ACC);
    chk(v_cnt == 1 && t_valid == t_rd_rise, "R10 valid pulse", v_cnt, 1);
  endtask

  task automatic t_byte_poll(input logic [11:0] v);
    clear_mon(); hang = 0; m_wide = 0; m_val = v; conv_len = 12;
    pulse_start(1, 0);
    wait_end();
    chk(result_o == v, "R9 byte result", result_o, v);
    chk(rd_falls == 2 && a0_seq[0] == 1'b0 && a0_seq[1] == 1'b1, "R9 a0 order",
        rd_falls, 2);
    chk(t_rd_rise - t_rd_fall == ACC, "R7 second read width", t_rd_rise - t_rd_fall, ACC);
    chk(v_cnt == 1 && t_valid == t_rd_rise, "R10 valid after low read", t_valid, t_rd_rise);
  endtask

  task automatic t_timeout(input logic [11:0] v, input bit wide);
    clear_mon(); hang = 1; m_wide = wide; m_val = v; conv_len = 0;
    pulse_start(0, wide);
    wait_end();
    chk(t_rd_fall1 - t_wr_rise == T, "R5 fixed wait", t_rd_fall1 - t_wr_rise, T);
    chk(result_o == v, "R5 timeout result", result_o, v);
    chk(!err_o, "R5 no error", err_o, 0);
    hang = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_watchdog();
    clear_mon(); hang = 1; m_wide = 1; m_val = 12'h123;
    pulse_start(1, 1);
    wait_end();
    chk(err_o && !busy_o, "R6 error raised", {err_o, busy_o}, 2);
    chk(rd_falls == 0, "R6 no read", rd_falls, 0);
    chk(t_err - t_wr_rise == 2 * T, "R6 watchdog time", t_err - t_wr_rise, 2 * T);
    chk(v_cnt == 0, "R6 no valid", v_cnt, 0);
    repeat (5) @(negedge clk);
    chk(err_o, "R6 error held", err_o, 1);
    hang = 0;
    @(negedge clk);
    sts = 1'b0;
    clear_mon(); m_val = 12'h456; conv_len = 8;
    pulse_start(1, 1);
    chk(!err_o, "R6 error cleared on start", err_o, 0);
    wait_end();
    chk(result_o == 12'h456, "R6 recovery result", result_o, 12'h456);
  endtask

  task automatic t_ignore_start();
    clear_mon(); hang = 0; m_wide = 0; m_val = 12'h9E7; conv_len = 20;
    pulse_start(1, 0);
    repeat (6) @(negedge clk);
    poll_mode_i = 0; wide_mode_i = 1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_end();
    chk(wr_falls == 1, "R3 start ignored while busy", wr_falls, 1);
    chk(rd_falls == 2, "R3 byte mode latched", rd_falls, 2);
    chk(result_o == 12'h9E7, "R3 result", result_o, 12'h9E7);
    chk(t_rd_fall1 - t_sts_fall == 1, "R3 status mode latched", t_rd_fall1 - t_sts_fall, 1);
    repeat (4) @(negedge clk);
    chk(!busy_o && wr_n_o, "R3 idle after", busy_o, 0);
    chk(result_o == 12'h9E7, "R10 result held", result_o, 12'h9E7);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_wide_poll(12'hABC, 15);
    t_wide_poll(12'h5F1, 60);
    t_byte_poll(12'h3D6);
    t_byte_poll(12'hF0F);
    t_timeout(12'h7A2, 1'b1);
    t_timeout(12'h81E, 1'b0);
    t_watchdog();
    t_ignore_start();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule